// File: doc/BRIEF.md
# Video Memory DMA Engine

This block moves data into a byte-addressed video memory on behalf of a display controller. It has three modes. It can stream 16-bit words from an external memory into video memory, replicate one byte across a range of video memory, or copy bytes from one place in video memory to another. The engine does at most one unit of work per access slot that the display timing grants it.

Word traffic, from the host data port or from an external transfer, goes through a small write queue. Each queued entry carries a release time, so it reaches video memory a fixed number of slots after it was queued. Fill and copy bypass the queue. They issue single-byte writes, but only while the queue is empty, so a byte write never overtakes a queued word.

Software first sets up the byte-wide source, length and step registers. It then issues a command that loads the destination address and a 6-bit command code. Bit 5 of the code requests a DMA operation; bits 3:0 equal to 0001 select video memory as the target.

Top module: `vdma_engine`

## Requirements
- R1: Bits 7:6 of the source-high register select the mode: 00 or 01 external transfer, 10 fill, 11 copy. The cfg_sel codes are 0 source-low, 1 source-middle, 2 source-high, 3 length-low, 4 length-high, 5 step. These registers are loaded from cfg_data.
- R2: While an external transfer is busy, each slot runs one unit, except a slot that directly follows a slot flagged as refresh. A unit reads the word at the 24-bit address {high,middle,low} and queues it for the current destination with the current command code.
- R3: After each unit, the 16-bit pair {middle,low} increments by one and wraps within itself. The source-high byte never changes.
- R4: After each unit, and after each accepted data-port write, the destination advances by the step register.
- R5: The 16-bit length decrements after each unit, and dma_busy drops when it reaches zero. A length of 0 at start runs 65536 units.
- R6: A queued entry is released on the first slot at least 16×LAT_SLOTS clocks after queuing when wide_mode was 1 at queuing, and 20×LAT_SLOTS clocks otherwise. Entries are released in order. The memory write appears one clock after release.
- R7: A released word with code bits 3:0 = 0001 writes its high byte at its address A and its low byte at A^1, in one vram_we cycle. vram_be[1] writes vram_wdata[15:8] at the even byte and vram_be[0] writes vram_wdata[7:0] at the odd byte of word vram_wword. Any other code discards the entry.
- R8: A data-port write when code bit 5 is set and the mode is fill starts a fill after queuing the word. Each fill unit then writes the high byte of that word at destination^1, and only on slots where the queue is empty.
- R9: A copy unit runs only on a slot flagged unused and only when the queue is empty. It reads the byte at {middle,low}^1 and writes it to destination^1.
- R10: dp_ready is high exactly when the engine is idle and the queue is not full. A data-port write is accepted on a clock edge where both dp_valid and dp_ready are high.
- R11: The queue holds at most FIFO_DEPTH (4) entries. An external transfer stalls, without reading, while the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | Selects 16-clock slots (1) or 20-clock slots (0) for release timing |
| cfg_we | input | 1 | Register write strobe, ignored while busy |
| cfg_sel | input | 3 | Register select code |
| cfg_data | input | 8 | Register write value |
| cmd_valid | input | 1 | Command strobe, ignored while busy |
| cmd_code | input | 6 | Command code |
| cmd_addr | input | 16 | Destination byte address |
| dp_valid | input | 1 | Data-port write offered |
| dp_ready | output | 1 | Data-port write can be accepted |
| dp_data | input | 16 | Data-port word |
| slot_valid | input | 1 | Access slot strobe |
| slot_refresh | input | 1 | This slot is a refresh slot |
| slot_unused | input | 1 | This slot is free for a copy |
| ext_rd_en | output | 1 | External read issued this clock |
| ext_rd_addr | output | 24 | External read address |
| ext_rd_data | input | 16 | External read word, same clock |
| vram_raddr | output | 16 | Video memory byte read address |
| vram_rdata | input | 8 | Video memory read byte, same clock |
| vram_we | output | 1 | Video memory write strobe |
| vram_wword | output | 15 | Video memory word address |
| vram_be | output | 2 | Byte lane enables |
| vram_wdata | output | 16 | Write data |
| dma_busy | output | 1 | A DMA operation is in progress |

## Verification
The bench aims at the carry rule of the source address. With the low byte at FF it must roll into the middle byte, and with both at FF the high byte must stay put. A design that carried into the high byte would read from the wrong bank. Release timing is checked to the exact clock in both slot widths, and an odd-address word must arrive lane-swapped. It also checks that a refresh-following slot is skipped, that transfers stall at a full queue, and that fill and copy hold off while a word is still queued, which an eager design would let through, with the byte-swapped addresses. A zero length must run 65536 fill units and not stop at once.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  localparam int VA_W   = 16;
  localparam int SRC_W  = 24;
  localparam int TS_W   = 16;
  localparam int CODE_W = 6;

  typedef enum logic [1:0] {
    MD_EXT_A = 2'b00,
    MD_EXT_B = 2'b01,
    MD_FILL  = 2'b10,
    MD_COPY  = 2'b11
  } dma_mode_e;

  localparam logic [2:0] SEL_SRC_LO = 3'd0;
  localparam logic [2:0] SEL_SRC_MD = 3'd1;
  localparam logic [2:0] SEL_SRC_HI = 3'd2;
  localparam logic [2:0] SEL_LEN_LO = 3'd3;
  localparam logic [2:0] SEL_LEN_HI = 3'd4;
  localparam logic [2:0] SEL_STEP   = 3'd5;

  localparam int DMA_REQ_BIT = 5;

  typedef struct packed {
    logic [VA_W-1:0]   addr;
    logic [15:0]       data;
    logic [CODE_W-1:0] code;
    logic [TS_W-1:0]   due;
  } wentry_t;

  function automatic logic targets_vram(input logic [CODE_W-1:0] c);
    return (c & 6'h0F) == 6'h01;
  endfunction

  function automatic logic is_ext(input dma_mode_e m);
    return (m == MD_EXT_A) || (m == MD_EXT_B);
  endfunction
endpackage

// File: rtl/vdma_wfifo.sv
module vdma_wfifo
  import vdma_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    push,
  input  wentry_t push_entry,
  input  logic    pop,
  output wentry_t head,
  output logic    empty,
  output logic    full
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IW-1:0] IMASK = IW'(DEPTH - 1);

  wentry_t       slots_q [DEPTH];
  logic [IW-1:0] wr_idx;
  logic [IW-1:0] rd_idx;
  logic          rd_live;
  logic [IW-1:0] wr_nxt;
  logic [IW-1:0] rd_nxt;

  assign wr_nxt = (wr_idx + 1'b1) & IMASK;
  assign rd_nxt = (rd_idx + 1'b1) & IMASK;
  assign empty  = !rd_live;
  assign full   = rd_live && (wr_idx == rd_idx);
  assign head   = slots_q[rd_idx];

  for (genvar g = 0; g < DEPTH; g++) begin : g_store
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slots_q[g] <= '0;
      end else if (push && (wr_idx == IW'(g))) begin
        slots_q[g] <= push_entry;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx  <= '0;
      rd_idx  <= '0;
      rd_live <= 1'b0;
    end else begin
      if (push) wr_idx <= wr_nxt;
      if (pop)  rd_idx <= rd_nxt;
      if (push) begin
        rd_live <= 1'b1;
      end else if (pop && (rd_nxt == wr_idx)) begin
        rd_live <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vdma_unit.sv
module vdma_unit
  import vdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [7:0]        cfg_data,
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic [VA_W-1:0]   cmd_addr,
  input  logic              dp_fire,
  input  logic [15:0]       dp_data,
  input  logic              slot_valid,
  input  logic              slot_refresh,
  input  logic              slot_unused,
  input  logic              fifo_empty,
  input  logic              fifo_full,
  input  logic [15:0]       ext_rd_data,
  input  logic [7:0]        vram_rdata,
  output logic              busy,
  output logic              unit_go,
  output logic              ext_rd_en,
  output logic [SRC_W-1:0]  ext_rd_addr,
  output logic [VA_W-1:0]   vram_raddr,
  output logic              q_push,
  output logic [VA_W-1:0]   q_addr,
  output logic [15:0]       q_data,
  output logic [CODE_W-1:0] q_code,
  output logic              byte_we,
  output logic [VA_W-1:0]   byte_addr,
  output logic [7:0]        byte_data,
  output logic [7:0]        src_hi_o
);
  logic [7:0]        src_hi, src_md, src_lo;
  logic [7:0]        len_hi, len_lo;
  logic [7:0]        step;
  logic [VA_W-1:0]   dest;
  logic [CODE_W-1:0] code;
  logic [7:0]        fill_val;
  logic              prev_ref;

  dma_mode_e         mode;
  logic              ext_go, fill_go, copy_go;
  logic [15:0]       src16, len_cur, len_nxt;
  logic [VA_W-1:0]   dest_stepped;

  assign mode         = dma_mode_e'(src_hi[7:6]);
  assign src16        = {src_md, src_lo};
  assign len_cur      = {len_hi, len_lo};
  assign len_nxt      = len_cur - 16'd1;
  assign dest_stepped = dest + {{(VA_W-8){1'b0}}, step};

  assign ext_go  = busy && is_ext(mode) && slot_valid && !prev_ref && !fifo_full;
  assign fill_go = busy && (mode == MD_FILL) && slot_valid && fifo_empty;
  assign copy_go = busy && (mode == MD_COPY) && slot_valid && slot_unused && fifo_empty;
  assign unit_go = ext_go || fill_go || copy_go;

  assign ext_rd_en   = ext_go;
  assign ext_rd_addr = {src_hi, src_md, src_lo};
  assign vram_raddr  = src16 ^ 16'h0001;

  assign q_push = ext_go || dp_fire;
  assign q_addr = dest;
  assign q_data = ext_go ? ext_rd_data : dp_data;
  assign q_code = code;

  assign byte_we   = fill_go || copy_go;
  assign byte_addr = dest ^ {{(VA_W-1){1'b0}}, 1'b1};
  assign byte_data = fill_go ? fill_val : vram_rdata;
  assign src_hi_o  = src_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_hi   <= '0;
      src_md   <= '0;
      src_lo   <= '0;
      len_hi   <= '0;
      len_lo   <= '0;
      step     <= '0;
      dest     <= '0;
      code     <= '0;
      fill_val <= '0;
      prev_ref <= 1'b0;
      busy     <= 1'b0;
    end else begin
      if (slot_valid) prev_ref <= slot_refresh;

      if (cfg_we && !busy) begin
        unique case (cfg_sel)
          SEL_SRC_LO: src_lo <= cfg_data;
          SEL_SRC_MD: src_md <= cfg_data;
          SEL_SRC_HI: src_hi <= cfg_data;
          SEL_LEN_LO: len_lo <= cfg_data;
          SEL_LEN_HI: len_hi <= cfg_data;
          SEL_STEP:   step   <= cfg_data;
          default: ;
        endcase
      end

      if (cmd_valid && !busy) begin
        dest <= cmd_addr;
        code <= cmd_code;
        if (cmd_code[DMA_REQ_BIT] && (mode != MD_FILL)) busy <= 1'b1;
      end

      if (dp_fire) begin
        dest <= dest_stepped;
        if (code[DMA_REQ_BIT] && (mode == MD_FILL)) begin
          busy     <= 1'b1;
          fill_val <= dp_data[15:8];
        end
      end

      if (unit_go) begin
        {src_md, src_lo} <= src16 + 16'd1;
        dest             <= dest_stepped;
        {len_hi, len_lo} <= len_nxt;
        if (len_nxt == 16'd0) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vdma_wport.sv
module vdma_wport
  import vdma_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            word_we,
  input  logic [VA_W-1:0] word_addr,
  input  logic [15:0]     word_data,
  input  logic            byte_we,
  input  logic [VA_W-1:0] byte_addr,
  input  logic [7:0]      byte_data,
  output logic            vram_we,
  output logic [VA_W-2:0] vram_wword,
  output logic [1:0]      vram_be,
  output logic [15:0]     vram_wdata
);
  logic [VA_W-1:0] sel_addr;
  logic [1:0]      be_n;
  logic [15:0]     data_n;

  assign sel_addr = word_we ? word_addr : byte_addr;

  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    // lane 1 is the even byte, lane 0 the odd byte
    localparam logic LANE_ODD = (ln == 0);
    always_comb begin
      if (word_we) begin
        be_n[ln]          = 1'b1;
        data_n[ln*8 +: 8] = (word_addr[0] == LANE_ODD) ? word_data[15:8] : word_data[7:0];
      end else begin
        be_n[ln]          = byte_we && (byte_addr[0] == LANE_ODD);
        data_n[ln*8 +: 8] = byte_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vram_we    <= 1'b0;
      vram_wword <= '0;
      vram_be    <= '0;
      vram_wdata <= '0;
    end else begin
      vram_we    <= word_we || byte_we;
      vram_wword <= sel_addr[VA_W-1:1];
      vram_be    <= be_n;
      vram_wdata <= data_n;
    end
  end
endmodule

// File: rtl/vdma_engine.sv
module vdma_engine
  import vdma_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int LAT_SLOTS  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wide_mode,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [7:0]  cfg_data,
  input  logic        cmd_valid,
  input  logic [5:0]  cmd_code,
  input  logic [15:0] cmd_addr,
  input  logic        dp_valid,
  output logic        dp_ready,
  input  logic [15:0] dp_data,
  input  logic        slot_valid,
  input  logic        slot_refresh,
  input  logic        slot_unused,
  output logic        ext_rd_en,
  output logic [23:0] ext_rd_addr,
  input  logic [15:0] ext_rd_data,
  output logic [15:0] vram_raddr,
  input  logic [7:0]  vram_rdata,
  output logic        vram_we,
  output logic [14:0] vram_wword,
  output logic [1:0]  vram_be,
  output logic [15:0] vram_wdata,
  output logic        dma_busy
);
  localparam logic [TS_W-1:0] LAT_WIDE   = TS_W'(16 * LAT_SLOTS);
  localparam logic [TS_W-1:0] LAT_NARROW = TS_W'(20 * LAT_SLOTS);

  logic [TS_W-1:0]   now;
  logic              fifo_push, fifo_pop, fifo_empty, fifo_full;
  wentry_t           push_entry, head;
  logic [TS_W-1:0]   age;
  logic              head_due;
  logic              dp_fire;
  logic              unit_go;
  logic [VA_W-1:0]   q_addr;
  logic [15:0]       q_data;
  logic [CODE_W-1:0] q_code;
  logic              byte_we;
  logic [VA_W-1:0]   byte_addr;
  logic [7:0]        byte_data;
  logic              word_we;
  logic [7:0]        src_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) now <= '0;
    else        now <= now + 1'b1;
  end

  assign dp_ready = !dma_busy && !fifo_full;
  assign dp_fire  = dp_valid && dp_ready;

  vdma_unit u_unit (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_data, .cmd_valid, .cmd_code, .cmd_addr,
    .dp_fire, .dp_data, .slot_valid, .slot_refresh, .slot_unused,
    .fifo_empty, .fifo_full, .ext_rd_data, .vram_rdata,
    .busy(dma_busy), .unit_go, .ext_rd_en, .ext_rd_addr, .vram_raddr,
    .q_push(fifo_push), .q_addr, .q_data, .q_code,
    .byte_we, .byte_addr, .byte_data, .src_hi_o(src_hi)
  );

  assign push_entry = '{addr: q_addr, data: q_data, code: q_code,
                        due: now + (wide_mode ? LAT_WIDE : LAT_NARROW)};

  vdma_wfifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk, .rst_n, .push(fifo_push), .push_entry, .pop(fifo_pop),
    .head, .empty(fifo_empty), .full(fifo_full)
  );

  assign age      = now - head.due;
  assign head_due = !age[TS_W-1];
  assign fifo_pop = slot_valid && !fifo_empty && head_due;
  assign word_we  = fifo_pop && targets_vram(head.code);

  vdma_wport u_wport (
    .clk, .rst_n, .word_we, .word_addr(head.addr), .word_data(head.data),
    .byte_we, .byte_addr, .byte_data,
    .vram_we, .vram_wword, .vram_be, .vram_wdata
  );
endmodule

module vdma_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_push,
  input logic       fifo_pop,
  input logic       fifo_full,
  input logic       fifo_empty,
  input logic       ext_rd_en,
  input logic       slot_valid,
  input logic       slot_refresh,
  input logic       byte_we,
  input logic       word_we,
  input logic       unit_go,
  input logic       dma_busy,
  input logic       dp_fire,
  input logic [7:0] src_hi
);
  logic last_ref;
  always_ff @(posedge clk) begin
    if (!rst_n)          last_ref <= 1'b0;
    else if (slot_valid) last_ref <= slot_refresh;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) fifo_full |-> !fifo_push); // R11
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) fifo_empty |-> !fifo_pop); // R6
  AST_SKIP_AFTER_REFRESH: assert property (@(posedge clk) disable iff (!rst_n) ext_rd_en |-> (slot_valid && !last_ref)); // R2
  AST_BYTE_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) byte_we |-> fifo_empty); // R8
  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n) !(byte_we && word_we)); // R7
  AST_BUSY_ENDS_ON_UNIT: assert property (@(posedge clk) disable iff (!rst_n) $fell(dma_busy) |-> $past(unit_go)); // R5
  AST_SRC_HI_HELD: assert property (@(posedge clk) disable iff (!rst_n) (dma_busy && $past(dma_busy)) |-> $stable(src_hi)); // R3
  AST_DP_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n) dp_fire |-> !dma_busy); // R10
endmodule

bind vdma_engine vdma_engine_chk u_chk (
  .clk, .rst_n, .fifo_push, .fifo_pop, .fifo_full, .fifo_empty, .ext_rd_en,
  .slot_valid, .slot_refresh, .byte_we, .word_we, .unit_go, .dma_busy, .dp_fire, .src_hi
);

// File: tb/test_vdma_engine.sv
`timescale 1ns/1ps
module test_vdma_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [7:0]  cfg_data = '0;
  logic        cmd_valid = 1'b0;
  logic [5:0]  cmd_code = '0;
  logic [15:0] cmd_addr = '0;
  logic        dp_valid = 1'b0;
  logic        dp_ready;
  logic [15:0] dp_data = '0;
  logic        slot_valid = 1'b1;
  logic        slot_refresh = 1'b0;
  logic        slot_unused = 1'b0;
  logic        ext_rd_en;
  logic [23:0] ext_rd_addr;
  logic [15:0] ext_rd_data;
  logic [15:0] vram_raddr;
  logic [7:0]  vram_rdata;
  logic        vram_we;
  logic [14:0] vram_wword;
  logic [1:0]  vram_be;
  logic [15:0] vram_wdata;
  logic        dma_busy;

  always #4 clk = ~clk;

  vdma_engine i_vdma_engine (.*);

  int checks = 0, failures = 0;
  bit done = 0;
  int cyc = 0, push_cyc = 0, wr_cyc = 0;
  int writes = 0, byte_writes = 0, ext_n = 0;
  logic [23:0] ext_log [16];
  logic [7:0]  vmem [65536];

  function automatic logic [7:0] init_val(input int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'h5A;
  endfunction

  function automatic logic [15:0] ext_val(input logic [23:0] a);
    return {a[7:0] ^ a[23:16], a[15:8] + 8'h3C};
  endfunction

  assign ext_rd_data = ext_val(ext_rd_addr);
  assign vram_rdata  = vmem[vram_raddr];

  initial for (int i = 0; i < 65536; i++) vmem[i] = init_val(i);

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (dp_valid && dp_ready) push_cyc = cyc;
    if (ext_rd_en) begin
      if (ext_n < 16) ext_log[ext_n] = ext_rd_addr;
      ext_n = ext_n + 1;
    end
    if (vram_we) begin
      writes = writes + 1;
      wr_cyc = cyc;
      if (vram_be != 2'b11) byte_writes = byte_writes + 1;
      if (vram_be[1]) vmem[{vram_wword, 1'b0}] <= vram_wdata[15:8];
      if (vram_be[0]) vmem[{vram_wword, 1'b1}] <= vram_wdata[7:0];
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_data = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic setup(input logic [23:0] src, input logic [15:0] len, input logic [7:0] st);
    cfg(3'd0, src[7:0]); cfg(3'd1, src[15:8]); cfg(3'd2, src[23:16]);
    cfg(3'd3, len[7:0]); cfg(3'd4, len[15:8]); cfg(3'd5, st);
  endtask

  task automatic cmd(input logic [5:0] c, input logic [15:0] a);
    @(negedge clk); cmd_valid = 1'b1; cmd_code = c; cmd_addr = a;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic dp_write(input logic [15:0] d);
    @(negedge clk);
    while (!dp_ready) @(negedge clk);
    dp_valid = 1'b1; dp_data = d;
    @(negedge clk); dp_valid = 1'b0;
  endtask

  task automatic wait_idle(input int limit);
    int n = 0;
    @(negedge clk);
    while (dma_busy && n < limit) begin @(negedge clk); n++; end
    repeat (50) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R5", dma_busy, 0, "busy after reset");
    check("R10", dp_ready, 1, "dp_ready after reset");
    check("R7", writes, 0, "no writes after reset");
  endtask

  task automatic t_latency;
    wide_mode = 1'b1;
    cmd(6'h01, 16'h0010);
    dp_write(16'hC3D4);
    repeat (50) @(negedge clk);
    check("R6", wr_cyc - push_cyc, 33, "wide release delay");
    check("R7", vmem[16'h0010], 8'hC3, "even word high byte");
    check("R7", vmem[16'h0011], 8'hD4, "even word low byte");
    wide_mode = 1'b0;
    cmd(6'h01, 16'h0012);
    dp_write(16'h1122);
    repeat (60) @(negedge clk);
    check("R6", wr_cyc - push_cyc, 41, "narrow release delay");
    wide_mode = 1'b1;
  endtask

  task automatic t_word_format;
    int w0;
    cmd(6'h01, 16'h0101);
    dp_write(16'h1234);
    repeat (50) @(negedge clk);
    check("R7", vmem[16'h0101], 8'h12, "odd word high byte at A");
    check("R7", vmem[16'h0100], 8'h34, "odd word low byte at A^1");
    w0 = writes;
    cmd(6'h03, 16'h0200);
    dp_write(16'hBEEF);
    repeat (50) @(negedge clk);
    check("R7", writes - w0, 0, "non-vram code writes nothing");
    check("R7", vmem[16'h0200], init_val(16'h0200), "non-vram target untouched");
  endtask

  task automatic t_ext;
    setup(24'h0112FE, 16'd4, 8'd2);
    ext_n = 0;
    cmd(6'h21, 16'h1000);
    wait_idle(200);
    check("R5", dma_busy, 0, "busy clears after length");
    check("R2", ext_n, 4, "external unit count");
    check("R3", ext_log[1], 24'h0112FF, "second source");
    check("R3", ext_log[2], 24'h011300, "low carries into middle");
    check("R1", ext_log[3], 24'h011301, "mode 00 streams externally");
    check("R2", vmem[16'h1000], ext_val(24'h0112FE) >> 8, "first word high");
    check("R4", vmem[16'h1007], ext_val(24'h011301) & 16'hFF, "step 2 destination");
  endtask

  task automatic t_carry;
    setup(24'h42FFFF, 16'd2, 8'd1);
    ext_n = 0;
    cmd(6'h21, 16'h1101);
    wait_idle(200);
    check("R1", ext_n, 2, "mode 01 streams externally");
    check("R3", ext_log[1], 24'h420000, "high byte never increments");
    check("R7", vmem[16'h1100], ext_val(24'h42FFFF) & 16'hFF, "odd dest low byte");
  endtask

  task automatic t_full;
    setup(24'h000100, 16'd8, 8'd2);
    ext_n = 0;
    cmd(6'h21, 16'h1200);
    repeat (6) @(negedge clk);
    check("R11", ext_n, 4, "stall at full queue");
    check("R5", dma_busy, 1, "still busy while stalled");
    wait_idle(500);
    check("R11", ext_n, 8, "all units after stall");
    check("R6", vmem[16'h120E], ext_val(24'h000107) >> 8, "last word in order");
  endtask

  task automatic t_refresh;
    setup(24'h000200, 16'd2, 8'd2);
    @(negedge clk); slot_valid = 1'b0;
    ext_n = 0;
    cmd(6'h21, 16'h1300);
    @(negedge clk); slot_valid = 1'b1; slot_refresh = 1'b1;
    @(negedge clk); slot_valid = 1'b0; slot_refresh = 1'b0;
    check("R2", ext_n, 1, "unit in refresh slot");
    @(negedge clk); slot_valid = 1'b1;
    @(negedge clk); slot_valid = 1'b0;
    check("R2", ext_n, 1, "slot after refresh skipped");
    @(negedge clk); slot_valid = 1'b1;
    @(negedge clk); slot_valid = 1'b0;
    check("R2", ext_n, 2, "next slot runs");
    slot_valid = 1'b1;
    wait_idle(200);
  endtask

  task automatic t_fill;
    int w0;
    setup(24'h800000, 16'd3, 8'd1);
    cmd(6'h21, 16'h2000);
    check("R8", dma_busy, 0, "fill waits for data word");
    w0 = writes;
    dp_write(16'hAB5C);
    repeat (10) @(negedge clk);
    check("R8", writes - w0, 0, "fill held while queue busy");
    check("R10", dp_ready, 0, "dp_ready low while busy");
    wait_idle(200);
    check("R8", vmem[16'h2000], 8'hAB, "fill byte at dest^1");
    check("R8", vmem[16'h2001], 8'h5C, "data word low byte kept");
    check("R8", vmem[16'h2002], 8'hAB, "fill third byte");
    check("R8", vmem[16'h2003], 8'hAB, "fill second byte");
  endtask

  task automatic t_copy;
    int w0;
    setup(24'hC03000, 16'd3, 8'd1);
    w0 = writes;
    cmd(6'h21, 16'h4000);
    repeat (10) @(negedge clk);
    check("R9", writes - w0, 0, "no copy without unused slot");
    check("R9", dma_busy, 1, "copy pending");
    slot_unused = 1'b1;
    wait_idle(200);
    slot_unused = 1'b0;
    check("R9", vmem[16'h4001], init_val(16'h3001), "copy unit 0");
    check("R9", vmem[16'h4000], init_val(16'h3000), "copy unit 1");
    check("R9", vmem[16'h4003], init_val(16'h3003), "copy unit 2");
    check("R9", vmem[16'h4002], init_val(16'h4002), "copy skips dest 4002");
  endtask

  task automatic t_len_zero;
    int b0;
    setup(24'h800000, 16'd0, 8'd0);
    cmd(6'h21, 16'h5000);
    b0 = byte_writes;
    dp_write(16'h7700);
    wait_idle(70000);
    check("R5", byte_writes - b0, 65536, "zero length runs 65536 units");
    check("R5", vmem[16'h5001], 8'h77, "fill byte landed");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_word_format();
    t_ext();
    t_carry();
    t_full();
    t_refresh();
    t_fill();
    t_copy();
    t_len_zero();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: all requirements, actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule